// File: doc/BRIEF.md
# Boot Image Header Locator

This block runs once after reset and decides how the chip boots. It first samples its health inputs and the boot-mode selector. If the supply is not good or the PLL is not locked, it stops without touching the boot device. For the two external-configuration modes it opens the external configuration path and does nothing else. For the serial-flash and card modes it searches the boot device for a valid image header.

A candidate header starts with the sync word 0x584C4E58. It is accepted only if its checksum word matches. Serial-flash modes step a writable multiboot offset. Card modes walk indexed image slots. Once a header is accepted, the block starts a copy of the loader into local RAM. It releases the loader processor only after the copy reports completion. If no header is found, it latches a lockdown state and raises its error pin.

Reads from the boot device use a request/valid handshake. The request may wait any number of cycles, and at most one read is outstanding at a time.

Top module: `boot_hdr_seek`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every control output is low (rd_req_o, cp_start_o, cpu_rel_o, ext_cfg_en_o, lockdown_o, err_o) and mb_o reads 0.
- R2: If vdd_ok_i or pll_ok_i was low when sampled, the block enters lockdown (lockdown_o and err_o high) without issuing any boot-device read.
- R3: Boot modes 0 (JTAG) and 1 (slave configuration port) raise ext_cfg_en_o and issue no reads, no copy and no release.
- R4: rd_req_o stays high with rd_addr_o unchanged until a cycle with rd_vld_i high. Each such cycle completes exactly one read.
- R5: A candidate at byte base B is read in word order B, B+4, and onward. It is accepted only if word 0 equals 0x584C4E58 and word HDR_WORDS (default 8) equals the bitwise inverse of the 32-bit sum of words 0..HDR_WORDS-1. A sync mismatch ends the candidate after word 0. A bad checksum is a miss.
- R6: In boot modes 2 (QSPI) and 3 (OSPI), the candidate base is mb_o × 32768, and each miss increments mb_o by one.
- R7: In serial-flash modes, if mb_o exceeds MB_MAX (default 256) before an attempt, the block enters lockdown without reading that candidate.
- R8: In boot modes 4 (SD) and 5 (eMMC), slots 0, 1, … are tried at slot × 32768 and mb_o does not change. After CARD_SLOTS (default 8191) misses the block enters lockdown.
- R9: On acceptance, cp_start_o pulses for one cycle with cp_base_o equal to the header base. cpu_rel_o rises only after cp_done_i is seen following that pulse. A cp_done_i at any other time has no effect.
- R10: lockdown_o, err_o, ext_cfg_en_o and cpu_rel_o stay in their final state until reset. Boot mode, vdd_ok_i and pll_ok_i are sampled only in the first cycle after reset.
- R11: Boot modes 6 and 7 enter lockdown with no reads.
- R12: A write on mb_we_i updates mb_o on the next edge unless a search or copy is under way. Writes during a search or copy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 3 | Boot-mode selector, sampled once |
| vdd_ok_i | input | 1 | Supply voltage good, sampled once |
| pll_ok_i | input | 1 | PLL locked, sampled once |
| mb_we_i | input | 1 | Multiboot register write enable |
| mb_wdata_i | input | MB_W | Multiboot write value |
| mb_o | output | MB_W | Current multiboot offset |
| rd_req_o | output | 1 | Boot-device read request |
| rd_addr_o | output | 32 | Read byte address |
| rd_vld_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 32 | Read data word |
| cp_start_o | output | 1 | One-cycle copy request |
| cp_base_o | output | 32 | Base of the accepted header |
| cp_done_i | input | 1 | Copy finished |
| cpu_rel_o | output | 1 | Loader processor release |
| ext_cfg_en_o | output | 1 | External configuration path enable |
| lockdown_o | output | 1 | Lockdown state |
| err_o | output | 1 | Error pin |

## Verification
The bench places headers whose sync word matches but whose checksum is bad. A design that trusted the sync word alone would boot from the wrong offset. The bench drives the multiboot offset just below and above its limit. An off-by-one in the limit would give one read too many, one too few, or no lockdown. It runs a card search through every slot to exhaustion, and puts two valid headers on a card, where the lower slot must win. It pulses a copy-done before any copy exists, which catches a release that does not wait for its own copy. It also changes the sampled inputs and writes the multiboot register mid-search. A design that resampled or accepted the write would then request different addresses.

// File: rtl/bhs_pkg.sv
package bhs_pkg;

  localparam logic [31:0] SYNC_WORD = 32'h584C4E58;

  localparam logic [2:0] BM_JTAG  = 3'd0;
  localparam logic [2:0] BM_SLAVE = 3'd1;
  localparam logic [2:0] BM_QSPI  = 3'd2;
  localparam logic [2:0] BM_OSPI  = 3'd3;
  localparam logic [2:0] BM_SD    = 3'd4;
  localparam logic [2:0] BM_EMMC  = 3'd5;

  typedef enum logic [3:0] {
    ST_SAMPLE, ST_VCHK, ST_PCHK, ST_MODE, ST_EXT, ST_SCHK,
    ST_READ, ST_STEP, ST_CPREQ, ST_CPWAIT, ST_RUN, ST_LOCK
  } bhs_state_e;

  function automatic logic mode_is_ext(input logic [2:0] m);
    return (m == BM_JTAG) || (m == BM_SLAVE);
  endfunction

  function automatic logic mode_is_flash(input logic [2:0] m);
    return (m == BM_QSPI) || (m == BM_OSPI);
  endfunction

  function automatic logic mode_is_card(input logic [2:0] m);
    return (m == BM_SD) || (m == BM_EMMC);
  endfunction

endpackage

// File: rtl/bhs_csum_acc.sv
module bhs_csum_acc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] sum_o
);

  logic [DW-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr_i)      sum_d = '0;
    else if (add_i) sum_d = sum_q + word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !add_i) |=> $stable(sum_o)); // R5

endmodule

// File: rtl/bhs_cursor.sv
module bhs_cursor #(
  parameter int MB_W       = 16,
  parameter int MB_MAX     = 256,
  parameter int SLOT_MAX   = 8191,
  parameter int STEP_SHIFT = 15,
  localparam int SLOT_W    = $clog2(SLOT_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flash_i,
  input  logic            step_i,
  input  logic            wr_ok_i,
  input  logic            we_i,
  input  logic [MB_W-1:0] wdata_i,
  output logic [MB_W-1:0] mb_o,
  output logic [31:0]     base_o,
  output logic            exhausted_o
);

  localparam logic [MB_W-1:0]   MB_LIM   = MB_W'(MB_MAX);
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(SLOT_MAX);

  logic [MB_W-1:0]   mb_q, mb_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              mb_en, slot_en;

  assign mb_en   = (step_i && flash_i) || (we_i && wr_ok_i);
  assign slot_en = step_i && !flash_i;

  always_comb begin
    mb_d   = mb_q;
    slot_d = slot_q;
    if (step_i && flash_i)   mb_d = mb_q + 1'b1;
    else if (we_i && wr_ok_i) mb_d = wdata_i;
    if (slot_en)             slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q   <= '0;
      slot_q <= '0;
    end else begin
      if (mb_en)   mb_q   <= mb_d;
      if (slot_en) slot_q <= slot_d;
    end
  end

  assign mb_o        = mb_q;
  assign base_o      = flash_i ? (32'(mb_q) << STEP_SHIFT) : (32'(slot_q) << STEP_SHIFT);
  assign exhausted_o = flash_i ? (mb_q > MB_LIM) : (slot_q >= SLOT_LIM);

  AST_MB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && flash_i) |=> (mb_o == $past(mb_o) + 1'b1)); // R6
  AST_CARD_KEEPS_MB: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !flash_i) |=> $stable(mb_o)); // R8
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wr_ok_i && !step_i) |=> $stable(mb_o)); // R12

endmodule

// File: rtl/boot_hdr_seek.sv
module boot_hdr_seek #(
  parameter int MB_W       = 16,
  parameter int MB_MAX     = 256,
  parameter int CARD_SLOTS = 8191,
  parameter int HDR_WORDS  = 8,
  parameter int STEP_SHIFT = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      boot_mode_i,
  input  logic            vdd_ok_i,
  input  logic            pll_ok_i,
  input  logic            mb_we_i,
  input  logic [MB_W-1:0] mb_wdata_i,
  output logic [MB_W-1:0] mb_o,
  output logic            rd_req_o,
  output logic [31:0]     rd_addr_o,
  input  logic            rd_vld_i,
  input  logic [31:0]     rd_data_i,
  output logic            cp_start_o,
  output logic [31:0]     cp_base_o,
  input  logic            cp_done_i,
  output logic            cpu_rel_o,
  output logic            ext_cfg_en_o,
  output logic            lockdown_o,
  output logic            err_o
);
  import bhs_pkg::*;

  localparam int              WIDX_W = $clog2(HDR_WORDS + 1);
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(HDR_WORDS);
  localparam logic [MB_W-1:0] MB_LIM = MB_W'(MB_MAX);

  bhs_state_e        state_q, state_d;
  logic [2:0]        mode_q;
  logic              vdd_q, pll_q, samp_en;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic              flash_sel, step, wr_ok, exhausted;
  logic              acc_clr, acc_add;
  logic [31:0]       base, sum;

  assign samp_en   = (state_q == ST_SAMPLE);
  assign flash_sel = mode_is_flash(mode_q);
  assign step      = (state_q == ST_STEP);
  assign wr_ok     = !(state_q inside {ST_SCHK, ST_READ, ST_STEP, ST_CPREQ, ST_CPWAIT});
  assign acc_clr   = (state_q == ST_SCHK);
  assign acc_add   = (state_q == ST_READ) && rd_vld_i && (widx_q != WIDX_LAST);

  bhs_cursor #(
    .MB_W(MB_W), .MB_MAX(MB_MAX), .SLOT_MAX(CARD_SLOTS), .STEP_SHIFT(STEP_SHIFT)
  ) u_cursor (
    .clk(clk), .rst_n(rst_n), .flash_i(flash_sel), .step_i(step),
    .wr_ok_i(wr_ok), .we_i(mb_we_i), .wdata_i(mb_wdata_i),
    .mb_o(mb_o), .base_o(base), .exhausted_o(exhausted)
  );

  bhs_csum_acc #(.DW(32)) u_csum (
    .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .add_i(acc_add),
    .word_i(rd_data_i), .sum_o(sum)
  );

  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    unique case (state_q)
      ST_SAMPLE: state_d = ST_VCHK;
      ST_VCHK:   state_d = vdd_q ? ST_PCHK : ST_LOCK;
      ST_PCHK:   state_d = pll_q ? ST_MODE : ST_LOCK;
      ST_MODE: begin
        if (mode_is_ext(mode_q))                              state_d = ST_EXT;
        else if (mode_is_flash(mode_q) || mode_is_card(mode_q)) state_d = ST_SCHK;
        else                                                  state_d = ST_LOCK;
      end
      ST_SCHK: begin
        widx_d  = '0;
        state_d = exhausted ? ST_LOCK : ST_READ;
      end
      ST_READ: begin
        if (rd_vld_i) begin
          if ((widx_q == '0) && (rd_data_i != SYNC_WORD)) state_d = ST_STEP;
          else if (widx_q == WIDX_LAST)
            state_d = (rd_data_i == ~sum) ? ST_CPREQ : ST_STEP;
          else widx_d = widx_q + 1'b1;
        end
      end
      ST_STEP:   state_d = ST_SCHK;
      ST_CPREQ:  state_d = ST_CPWAIT;
      ST_CPWAIT: if (cp_done_i) state_d = ST_RUN;
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SAMPLE;
      widx_q  <= '0;
      mode_q  <= '0;
      vdd_q   <= 1'b0;
      pll_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      if (samp_en) begin
        mode_q <= boot_mode_i;
        vdd_q  <= vdd_ok_i;
        pll_q  <= pll_ok_i;
      end
    end
  end

  assign rd_req_o     = (state_q == ST_READ);
  assign rd_addr_o    = base + 32'({widx_q, 2'b00});
  assign cp_start_o   = (state_q == ST_CPREQ);
  assign cp_base_o    = base;
  assign cpu_rel_o    = (state_q == ST_RUN);
  assign ext_cfg_en_o = (state_q == ST_EXT);
  assign lockdown_o   = (state_q == ST_LOCK);
  assign err_o        = (state_q == ST_LOCK);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_vld_i) |=> (rd_req_o && $stable(rd_addr_o))); // R4
  AST_EXT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cfg_en_o |-> (!rd_req_o && !cp_start_o)); // R3
  AST_REL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rel_o) |-> $past(cp_done_i)); // R9
  AST_CP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start_o |=> !cp_start_o); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown_o |=> (lockdown_o && err_o)); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lockdown_o, ext_cfg_en_o, cpu_rel_o})); // R10
  AST_FLASH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && flash_sel) |-> (mb_o <= MB_LIM)); // R7

endmodule

// File: tb/boot_hdr_seek_tb.sv
module boot_hdr_seek_tb_top;

  localparam logic [31:0] SYNC = 32'h584C4E58;
  localparam int K_BOOT = 0, K_EXT = 1, K_LOCK = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  boot_mode = '0;
  logic        vdd_ok = 1'b1, pll_ok = 1'b1;
  logic        mb_we = 1'b0;
  logic [15:0] mb_wdata = '0;
  logic [15:0] mb;
  logic        rd_req, rd_vld = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        cp_start, cp_done = 1'b0;
  logic [31:0] cp_base;
  logic        cpu_rel, ext_en, lockd, err;

  always #2 clk = ~clk;

  boot_hdr_seek dut_i (
    .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode), .vdd_ok_i(vdd_ok),
    .pll_ok_i(pll_ok), .mb_we_i(mb_we), .mb_wdata_i(mb_wdata), .mb_o(mb),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_vld_i(rd_vld), .rd_data_i(rd_data),
    .cp_start_o(cp_start), .cp_base_o(cp_base), .cp_done_i(cp_done),
    .cpu_rel_o(cpu_rel), .ext_cfg_en_o(ext_en), .lockdown_o(lockd), .err_o(err)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_q[$];
  int          exp_kind;
  logic [31:0] exp_base;
  int          exp_mb;
  string       cur_tag = "R1";
  bit          done_seen, started_cp;
  int          rd_cnt, since_rst;
  int          lat = 0;
  bit          pend = 0;
  logic [31:0] pend_addr;
  int          cp_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic put_hdr(input logic [31:0] b, input bit good);
    logic [31:0] s = '0;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w = (k == 0) ? SYNC : (b ^ (32'h1357_9BDF * k));
      mem[b + 4*k] = w;
      s += w;
    end
    mem[b + 32] = good ? ~s : (~s ^ 32'h10);
  endtask

  // Behavioural outcome model: expected read addresses and final result
  task automatic build_exp(input logic [2:0] m, input bit v, input bit p, input int mb0);
    exp_q.delete();
    exp_mb = mb0;
    exp_base = '0;
    if (!v || !p || m > 5) begin exp_kind = K_LOCK; return; end
    if (m <= 1) begin exp_kind = K_EXT; return; end
    exp_kind = K_LOCK;
    for (int idx = (m <= 3) ? mb0 : 0; ; idx++) begin
      logic [31:0] b, s;
      if (m <= 3 && idx > 256) break;
      if (m >= 4 && idx >= 8191) break;
      b = idx << 15;
      if (m <= 3) exp_mb = idx;
      exp_q.push_back(b);
      if (rdm(b) != SYNC) continue;
      s = '0;
      for (int k = 0; k < 8; k++) begin
        if (k > 0) exp_q.push_back(b + 4*k);
        s += rdm(b + 4*k);
      end
      exp_q.push_back(b + 32);
      if (rdm(b + 32) == ~s) begin exp_kind = K_BOOT; exp_base = b; break; end
    end
    if (m <= 3 && exp_kind == K_LOCK) exp_mb = (mb0 > 256) ? mb0 : 257;
  endtask

  // Read responder with random wait cycles, address compare against model
  always @(negedge clk) begin
    rd_vld = 1'b0;
    if (!rst_n) begin
      pend = 0;
      lat = 0;
    end else if (rd_req) begin
      if (pend) chk(rd_addr == pend_addr, "R4", rd_addr, pend_addr);
      if (lat == 0) begin
        logic [31:0] e;
        rd_data = rdm(rd_addr);
        rd_vld = 1'b1;
        rd_cnt++;
        if (exp_q.size() == 0) chk(1'b0, cur_tag, rd_addr, 32'hFFFF_FFFF);
        else begin
          e = exp_q.pop_front();
          chk(rd_addr == e, cur_tag, rd_addr, e);
        end
        pend = 0;
        lat = $urandom_range(0, 3);
      end else begin
        lat--;
        pend = 1;
        pend_addr = rd_addr;
      end
    end
  end

  // Copy engine model, plus a stray done pulse early after every reset
  always @(negedge clk) begin
    cp_done = 1'b0;
    if (!rst_n) begin
      cp_cnt = 0;
      since_rst = 0;
    end else begin
      since_rst++;
      if (since_rst == 3) cp_done = 1'b1;
      if (cp_start) begin
        started_cp = 1;
        chk(cp_base == exp_base, "R9", cp_base, exp_base);
        cp_cnt = 3;
      end else if (cp_cnt > 0) begin
        cp_cnt--;
        if (cp_cnt == 0) begin
          cp_done = 1'b1;
          done_seen = 1;
        end
      end
    end
  end

  // Per-cycle comparison against the expected outcome
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(err == lockd, "R10", {31'b0, err}, {31'b0, lockd});
      if (lockd)   chk(exp_kind == K_LOCK, cur_tag, 32'(exp_kind), K_LOCK);
      if (ext_en)  chk(exp_kind == K_EXT, "R3", 32'(exp_kind), K_EXT);
      if (cpu_rel) chk(done_seen, "R9", {31'b0, done_seen}, 32'd1);
      if (rd_req)  chk(exp_kind != K_EXT, "R3", 32'(exp_kind), K_BOOT);
    end
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd190000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic run_case(input string tag, input logic [2:0] m, input bit v, input bit p,
                          input bit wr, input int wval, input bit midwr);
    int t;
    cur_tag = tag;
    rst_n = 1'b0;
    boot_mode = m; vdd_ok = v; pll_ok = p;
    build_exp(m, v, p, wr ? wval : 0);
    done_seen = 0; started_cp = 0; rd_cnt = 0;
    repeat (2) @(negedge clk);
    chk({rd_req, cp_start, cpu_rel, ext_en, lockd, err} == 6'b0 && mb == 16'h0, "R1",
        {26'b0, rd_req, cp_start, cpu_rel, ext_en, lockd, err}, 32'h0);
    mb_we = wr; mb_wdata = 16'(wval);
    rst_n = 1'b1;
    @(negedge clk);
    mb_we = 1'b0;
    chk({rd_req, cp_start, cpu_rel, ext_en, lockd} == 5'b0, "R1",
        {27'b0, rd_req, cp_start, cpu_rel, ext_en, lockd}, 32'h0);
    // R10: changes after the sampling cycle must be ignored
    boot_mode = ~m; vdd_ok = ~v; pll_ok = ~p;
    t = 0;
    while (!(cpu_rel || ext_en || lockd) && t < 60000) begin
      if (midwr && rd_cnt == 2) begin mb_we = 1'b1; mb_wdata = 16'h0; end
      else mb_we = 1'b0;
      @(negedge clk);
      t++;
    end
    mb_we = 1'b0;
    chk(t < 60000, {tag, " timeout"}, 32'(t), 32'd60000);
    chk((exp_kind == K_BOOT && cpu_rel) || (exp_kind == K_EXT && ext_en) ||
        (exp_kind == K_LOCK && lockd && err), tag, {29'b0, cpu_rel, ext_en, lockd}, 32'(exp_kind));
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    chk(mb == 16'(exp_mb), tag, {16'b0, mb}, 32'(exp_mb));
    if (exp_kind == K_BOOT) chk(started_cp, "R9", {31'b0, started_cp}, 32'd1);
    repeat (5) @(negedge clk);
    chk((exp_kind == K_BOOT && cpu_rel) || (exp_kind == K_EXT && ext_en) ||
        (exp_kind == K_LOCK && lockd), "R10", {29'b0, cpu_rel, ext_en, lockd}, 32'(exp_kind));
  endtask

  initial begin
    // R5 R9: good header at offset zero on QSPI
    mem.delete(); put_hdr(32'h0, 1);
    run_case("R5", 3'd2, 1, 1, 0, 0, 0);
    // R12: write after the outcome is accepted
    mb_we = 1'b1; mb_wdata = 16'h00A5;
    @(negedge clk); mb_we = 1'b0;
    chk(mb == 16'h00A5, "R12", {16'b0, mb}, 32'hA5);

    // R6 R12: OSPI from offset 1, bad checksum at 1, junk at 2, good at 3
    mem.delete(); put_hdr(32'd1 << 15, 0); mem[32'd2 << 15] = 32'hDEAD_BEEF; put_hdr(32'd3 << 15, 1);
    run_case("R6", 3'd3, 1, 1, 1, 1, 1);

    // R7: search from 250 runs past the limit
    mem.delete();
    run_case("R7", 3'd2, 1, 1, 1, 250, 0);
    // R7: start already above the limit, no reads
    mem.delete();
    run_case("R7", 3'd2, 1, 1, 1, 300, 0);
    chk(rd_cnt == 0, "R7", 32'(rd_cnt), 32'd0);

    // R8: SD, lower of two good slots wins, mb untouched
    mem.delete(); put_hdr(32'd5 << 15, 1); put_hdr(32'd9 << 15, 1);
    run_case("R8", 3'd4, 1, 1, 1, 7, 0);
    // R8: eMMC with no header tries every slot
    mem.delete();
    run_case("R8", 3'd5, 1, 1, 0, 0, 0);
    chk(rd_cnt == 8191, "R8", 32'(rd_cnt), 32'd8191);

    // R3: both external modes
    mem.delete(); put_hdr(32'h0, 1);
    run_case("R3", 3'd0, 1, 1, 0, 0, 0);
    chk(rd_cnt == 0, "R3", 32'(rd_cnt), 32'd0);
    run_case("R3", 3'd1, 1, 1, 0, 0, 0);

    // R2: health failures with a valid header present
    run_case("R2", 3'd2, 0, 1, 0, 0, 0);
    chk(rd_cnt == 0, "R2", 32'(rd_cnt), 32'd0);
    run_case("R2", 3'd2, 1, 0, 0, 0, 0);
    chk(rd_cnt == 0, "R2", 32'(rd_cnt), 32'd0);

    // R11: reserved modes
    run_case("R11", 3'd6, 1, 1, 0, 0, 0);
    run_case("R11", 3'd7, 1, 1, 0, 0, 0);
    chk(rd_cnt == 0, "R11", 32'(rd_cnt), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule